// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block performs single write transactions to an external asynchronous static RAM with a 19-bit address and an 8-bit data bus, from inside a synchronous clock domain. A host presents a request with an address and a byte. The block takes the transaction when it shows ready, runs the memory pins through a fixed sequence of phases, and signals completion with a one-cycle done pulse. The memory side has an address bus, a write-data bus with a separate drive enable, and active-low chip select, write enable and output enable.

All of the memory's nanosecond limits are turned into whole clock counts at elaboration time. The inputs are a clock-period parameter and a speed-grade parameter: grade 0 is the 70 ns part and grade 1 is the 85 ns part. Each phase length is a ceiling division of the limit by the period, and a limit of zero still gets one cycle.

Output enable can be held low during writes. In that case the memory may still be driving the bus when write enable falls. The write pulse is then made long enough to cover the memory's worst-case turn-off time plus the data setup time, and the block turns its own data drive on only after that turn-off time has passed. This avoids bus contention.

Top module: `sram_wr_seq`

## Requirements
- R1: During reset and after its release with no request, chip select and write enable are high (inactive), the data drive enable is 0, ready is 1 and done is 0.
- R2: A request is taken only when ready is 1. Ready drops in the cycle after a request is taken and stays low until the sequence ends. Requests and host address or data changes made while ready is low do not affect the write in progress.
- R3: Write enable stays low for at least the write-pulse minimum: 50 ns for grade 0, 55 ns for grade 1. For grade 0 with OE held low at an 8 ns clock, this is 8 cycles.
- R4: From chip select falling to write enable rising is at least 60 ns (grade 0). From the address becoming valid to write enable rising is also at least 60 ns (grade 0).
- R5: The address and write data do not change while chip select is low, so address setup and write recovery are never negative.
- R6: The write data is driven for at least 30 ns (grade 0) before write enable rises, and it is still driven when write enable rises.
- R7: The data drive enable turns on only while write enable is low, and only at least 30 ns (grade 0) after write enable fell. This is the memory's worst-case output turn-off time when OE is held low.
- R8: The data drive enable turns off exactly one clock cycle after write enable rises.
- R9: Chip select falls at least one cycle before write enable falls, and write enable is low only while chip select is low.
- R10: Done is high for exactly one cycle, in the same cycle that chip select returns high. At the default parameters it comes 10 rising edges after the edge that took the request.
- R11: Each accepted request writes its own address and byte into the memory, in acceptance order.
- R12: Two successive write cycles start at least 70 ns apart (grade 0), measured from chip select falling to chip select falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Write request |
| host_addr | input | 19 | Write address, captured when the request is taken |
| host_wdata | input | 8 | Write byte, captured when the request is taken |
| host_ready | output | 1 | Block is idle and will take a request this cycle |
| host_done | output | 1 | One-cycle pulse at the end of a write |
| mem_addr | output | 19 | Memory address |
| mem_dq | output | 8 | Memory write data |
| mem_dq_oe | output | 1 | Drive enable for mem_dq |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
At the defaults (grade 0, 8 ns clock, OE held low), each output has a fixed cycle after the rising edge that takes a request:
- Chip select falls and the address appears at that same edge.
- Write enable falls one edge later.
- The data drive turns on four edges after write enable falls.
- Write enable rises eight edges after it fell.
- The drive releases one edge after that, together with done.

The bench drives inputs 2 ns after a rising edge and samples every pin at the falling edge. It numbers falling edges. Each measured interval is the difference of two edge numbers times 8 ns, compared with the nanosecond limit. Done is expected exactly 11 falling edges after the falling edge at which the bench saw request and ready both high.

// File: rtl/sram_wr_pkg.sv
`timescale 1ns/1ps
package sram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_PULSE   = 2'd2,
    ST_RECOVER = 2'd3
  } wr_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

  // grade 0: fast part, grade 1: slow part
  function automatic int unsigned lim_cycle(input int unsigned g);  return (g == 0) ? 70 : 85; endfunction
  function automatic int unsigned lim_cs_end(input int unsigned g); return (g == 0) ? 60 : 75; endfunction
  function automatic int unsigned lim_ad_end(input int unsigned g); return (g == 0) ? 60 : 75; endfunction
  function automatic int unsigned lim_pulse(input int unsigned g);  return (g == 0) ? 50 : 55; endfunction
  function automatic int unsigned lim_dsetup(input int unsigned g); return (g == 0) ? 30 : 35; endfunction
  function automatic int unsigned lim_turnoff(input int unsigned g);return (g == 0) ? 30 : 35; endfunction

endpackage

// File: rtl/sram_wr_fsm.sv
`timescale 1ns/1ps
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 8,
  parameter int unsigned REC_CYC   = 1,
  parameter int unsigned CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  output logic             ready,
  output logic             accept,
  output wr_state_e        nxt_state,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             done
);

  wr_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_d;

  assign ready  = (state_q == ST_IDLE);
  assign accept = req && ready;

  always_comb begin
    nxt_state = state_q;
    nxt_cnt   = cnt_q + 1'b1;
    done_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        nxt_cnt = '0;
        if (req) nxt_state = ST_SETUP;
      end
      ST_SETUP: begin
        if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
          nxt_state = ST_PULSE;
          nxt_cnt   = '0;
        end
      end
      ST_PULSE: begin
        if (cnt_q == CNT_W'(PULSE_CYC - 1)) begin
          nxt_state = ST_RECOVER;
          nxt_cnt   = '0;
        end
      end
      ST_RECOVER: begin
        if (cnt_q == CNT_W'(REC_CYC - 1)) begin
          nxt_state = ST_IDLE;
          nxt_cnt   = '0;
          done_d    = 1'b1;
        end
      end
      default: begin
        nxt_state = ST_IDLE;
        nxt_cnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= nxt_state;
      cnt_q   <= nxt_cnt;
      done    <= done_d;
    end
  end

  // R2: a taken request makes the block busy on the next cycle
  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // R10: done lasts a single cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done appears with the block back in idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

endmodule

// File: rtl/sram_wr_pins.sv
`timescale 1ns/1ps
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned TURN_CYC    = 4,
  parameter bit          OE_HELD_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  wr_state_e         nxt_state,
  input  logic [CNT_W-1:0]  nxt_cnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq,
  output logic              mem_dq_oe,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  logic turn_ok;
  logic drive_d;
  logic cs_n_d;
  logic we_n_d;

  generate
    if (TURN_CYC > 0) begin : g_turn_wait
      assign turn_ok = (nxt_cnt >= CNT_W'(TURN_CYC));
    end else begin : g_turn_none
      assign turn_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    cs_n_d  = (nxt_state == ST_IDLE);
    we_n_d  = (nxt_state != ST_PULSE);
    drive_d = ((nxt_state == ST_PULSE) && turn_ok) ||
              ((nxt_state == ST_RECOVER) && (nxt_cnt == '0));
  end

  // strobes are registered from next-state so pins never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs_n  <= cs_n_d;
      mem_we_n  <= we_n_d;
      mem_dq_oe <= drive_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq   <= '0;
    end else if (accept) begin
      mem_addr <= host_addr;
      mem_dq   <= host_wdata;
    end
  end

  assign mem_oe_n = OE_HELD_LOW ? 1'b0 : 1'b1;

  // R9: write enable low only inside chip select low
  p_we_in_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  // R9: chip select was already low before write enable fell
  p_cs_leads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n));

  // R7: data drive only while write enable is low or in the release cycle
  p_drive_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_cs_n);

  // R5: address and data stay fixed while chip select is low
  p_bus_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dq)));

  // R6: data still driven at the end of the write
  p_data_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  // R8: drive released one cycle after write enable rises
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe);

endmodule

// File: rtl/sram_wr_seq.sv
`timescale 1ns/1ps
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CLK_NS      = 8,
  parameter int unsigned SPEED_GRADE = 0,
  parameter bit          OE_HELD_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq,
  output logic              mem_dq_oe,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int unsigned G = SPEED_GRADE;
  // address setup is 0 ns, so one cycle is the floor
  localparam int unsigned SETUP_CYC = 1;
  localparam int unsigned TURN_CYC  = OE_HELD_LOW ? ns_to_cyc(lim_turnoff(G), CLK_NS) : 0;
  localparam int unsigned PULSE_CYC = max_u(
      max_u(ns_to_cyc(lim_pulse(G), CLK_NS), TURN_CYC + ns_to_cyc(lim_dsetup(G), CLK_NS)),
      max_u(sat_sub(ns_to_cyc(lim_cs_end(G), CLK_NS), SETUP_CYC),
            sat_sub(ns_to_cyc(lim_ad_end(G), CLK_NS), SETUP_CYC)));
  localparam int unsigned REC_CYC   = max_u(1,
      sat_sub(ns_to_cyc(lim_cycle(G), CLK_NS), SETUP_CYC + PULSE_CYC));
  localparam int unsigned MAX_CYC   = max_u(max_u(SETUP_CYC, PULSE_CYC), REC_CYC);
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  wr_state_e        nxt_state;
  logic [CNT_W-1:0] nxt_cnt;
  logic             accept;

  sram_wr_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .REC_CYC   (REC_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (host_req),
    .ready     (host_ready),
    .accept    (accept),
    .nxt_state (nxt_state),
    .nxt_cnt   (nxt_cnt),
    .done      (host_done)
  );

  sram_wr_pins #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .TURN_CYC    (TURN_CYC),
    .OE_HELD_LOW (OE_HELD_LOW)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .nxt_state  (nxt_state),
    .nxt_cnt    (nxt_cnt),
    .mem_addr   (mem_addr),
    .mem_dq     (mem_dq),
    .mem_dq_oe  (mem_dq_oe),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n)
  );

  // R10: the end of chip select and done coincide
  p_done_with_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> host_done);

endmodule

// File: tb/tb_sram_wr_seq.sv
`timescale 1ns/1ps
module tb_sram_wr_seq;

  localparam int P     = 8;
  localparam int T_WC  = 70;
  localparam int T_CW  = 60;
  localparam int T_AW  = 60;
  localparam int T_WP  = 50;
  localparam int T_DW  = 30;
  localparam int T_WHZ = 30;
  localparam int DONE_LAG = 11; // falling edges from seen-accept to seen-done

  logic        clk;
  logic        rst_n;
  logic        host_req;
  logic [18:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_ready;
  logic        host_done;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq;
  logic        mem_dq_oe;
  logic        mem_cs_n;
  logic        mem_we_n;
  logic        mem_oe_n;

  sram_wr_seq dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_ready (host_ready),
    .host_done  (host_done),
    .mem_addr   (mem_addr),
    .mem_dq     (mem_dq),
    .mem_dq_oe  (mem_dq_oe),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  typedef struct { logic [18:0] a; logic [7:0] d; } item_t;
  item_t sbq[$];
  int    accq[$];
  logic [7:0] exp_mem [logic [18:0]];
  logic [7:0] model_mem [logic [18:0]];
  int n_written = 0;
  int n_pushed  = 0;

  // ---------------- driver ----------------
  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    item_t it;
    host_req   = 1'b1;
    host_addr  = a;
    host_wdata = d;
    forever begin
      @(negedge clk);
      if (host_ready) break;
    end
    it.a = a; it.d = d;
    sbq.push_back(it);
    exp_mem[a] = d;
    n_pushed++;
    @(posedge clk); #2;
    host_req = 1'b0;
  endtask

  task automatic scramble_busy(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      host_addr  = 19'($urandom);
      host_wdata = 8'($urandom);
      @(posedge clk); #2;
    end
  endtask

  // ---------------- monitor / memory model ----------------
  int  n = 0;
  int  t_cs = -1, t_prev_cs = -1, t_we = -1, t_addr = -1, t_data = -1;
  logic p_cs_n = 1'b1, p_we_n = 1'b1, p_oe = 1'b0, p_done = 1'b0;
  logic [18:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  bit   rel_due = 0;
  bit   mon_on = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      n++;
      if (host_req && host_ready) accq.push_back(n);
      // chip select falls: new write cycle
      if (p_cs_n && !mem_cs_n) begin
        t_prev_cs = t_cs;
        t_cs = n;
        t_addr = n;
        if (t_prev_cs >= 0)
          chk((t_cs - t_prev_cs) * P >= T_WC, "R12 cycle time ns", (t_cs - t_prev_cs) * P, T_WC);
        chk(mem_we_n == 1'b1, "R9 we high at cs fall", int'(mem_we_n), 1);
      end
      if (!p_cs_n && !mem_cs_n)
        chk(mem_addr == p_addr && mem_dq == p_dq, "R5 bus stable under cs", int'(mem_addr), int'(p_addr));
      if (p_we_n && !mem_we_n) begin
        t_we = n;
        chk(!p_cs_n, "R9 cs low a cycle before we", int'(p_cs_n), 0);
      end
      if (!mem_we_n)
        chk(!mem_cs_n, "R9 we low inside cs", int'(mem_cs_n), 0);
      if (!p_oe && mem_dq_oe) begin
        t_data = n;
        chk(!mem_we_n && (n - t_we) * P >= T_WHZ, "R7 drive after turn-off", (n - t_we) * P, T_WHZ);
      end
      if (rel_due) begin
        chk(!mem_dq_oe, "R8 drive released", int'(mem_dq_oe), 0);
        rel_due = 0;
      end
      // end of write
      if (!p_we_n && mem_we_n) begin
        item_t it;
        chk((n - t_we) * P >= T_WP, "R3 pulse ns", (n - t_we) * P, T_WP);
        chk((n - t_we) == 8, "R3 pulse cycles", n - t_we, 8);
        chk((n - t_cs) * P >= T_CW, "R4 cs to end ns", (n - t_cs) * P, T_CW);
        chk((n - t_addr) * P >= T_AW, "R4 addr to end ns", (n - t_addr) * P, T_AW);
        chk(mem_dq_oe && (n - t_data) * P >= T_DW, "R6 data setup ns", (n - t_data) * P, T_DW);
        rel_due = 1;
        if (sbq.size() == 0) begin
          chk(0, "R2 write without accepted request", 1, 0);
        end else begin
          it = sbq.pop_front();
          chk(mem_addr == it.a, "R11 address", int'(mem_addr), int'(it.a));
          chk(mem_dq == it.d, "R11 data", int'(mem_dq), int'(it.d));
        end
        model_mem[mem_addr] = mem_dq;
        n_written++;
      end
      if (host_done) begin
        int a;
        a = (accq.size() > 0) ? accq.pop_front() : -100;
        chk(n == a + DONE_LAG, "R10 done latency", n - a, DONE_LAG);
        chk(!p_cs_n && mem_cs_n, "R10 done with cs rise", int'(mem_cs_n), 1);
        chk(host_ready, "R2 ready back with done", int'(host_ready), 1);
      end
      if (p_done)
        chk(!host_done, "R10 done one cycle", int'(host_done), 0);
      if (!mem_cs_n && host_ready)
        chk(0, "R2 ready while busy", 1, 0);
      p_cs_n = mem_cs_n; p_we_n = mem_we_n; p_oe = mem_dq_oe;
      p_done = host_done; p_addr = mem_addr; p_dq = mem_dq;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_main();
    host_req = 1'b0; host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && !mem_dq_oe, "R1 strobes in reset", int'({mem_cs_n, mem_we_n, mem_dq_oe}), 6);
    chk(host_ready && !host_done, "R1 handshake in reset", int'({host_ready, host_done}), 2);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && !mem_dq_oe && host_ready && !host_done,
        "R1 idle after reset", int'({mem_cs_n, mem_we_n, mem_dq_oe, host_ready, host_done}), 26);
    mon_on = 1;
    @(posedge clk); #2;
    // single writes, boundary addresses and data
    do_write(19'h00000, 8'h00);
    repeat (14) @(posedge clk); #2;
    do_write(19'h7FFFF, 8'hFF);
    repeat (14) @(posedge clk); #2;
    // back-to-back with request held high through busy (R2, R12)
    do_write(19'h12345, 8'hA5);
    do_write(19'h54321, 8'h5A);
    do_write(19'h00001, 8'h3C);
    // inputs changing while busy must not alter the write (R2)
    do_write(19'h2AAAA, 8'h81);
    scramble_busy(8);
    repeat (6) @(posedge clk); #2;
    // request asserted mid-sequence and held
    do_write(19'h15555, 8'h7E);
    @(posedge clk); #2;
    do_write(19'h15555, 8'h42); // overwrite same address
    repeat (20) @(posedge clk); #2;
    chk(sbq.size() == 0, "R11 scoreboard drained", sbq.size(), 0);
    chk(n_written == n_pushed, "R2 one write per accept", n_written, n_pushed);
    foreach (exp_mem[k])
      chk(model_mem.exists(k) && model_mem[k] == exp_mem[k], "R11 memory content",
          model_mem.exists(k) ? int'(model_mem[k]) : -1, int'(exp_mem[k]));
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule